// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an analog-to-digital conversion sequence begins. Software writes the conversion-control register, which raises a one-cycle start strobe. Depending on the mode bits, that strobe either launches sequences at once or only arms the block so that an external trigger pin launches them. The conversion engine answers each sequence with a one-cycle done pulse. The sequencer then decides whether to stop, rearm or start the next sequence straight away.

The trigger pin is asynchronous. It passes through a two-stage synchronizer, and edges are found by comparing consecutive synchronized samples. In edge mode, a qualifying edge that arrives during a running sequence is recorded in a sticky overrun flag and is not queued. In level mode, the trigger dropping and returning during a sequence is not an overrun. A trigger still at its active level when a sequence ends starts the next sequence at once. Every pin is plain control or status; the block has no data stream.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `busy`, `seq_start` and `ovr_flag` are 0 and no sequence starts until `start_req` is seen.
- R2: With `trig_en`=0 and `scan_cont`=0, `start_req` makes `seq_start` and `busy` high in the next cycle. `seq_start` lasts one cycle and `busy` stays high until the cycle after `conv_done`, after which the block is idle. Exactly one sequence runs.
- R3: With `trig_en`=0 and `scan_cont`=1, each `conv_done` during a sequence gives a new `seq_start` in the next cycle, so `busy` stays high. `trig_in` has no effect.
- R4: With `trig_en`=1 and `level_mode`=0, a rising edge (`polarity`=1) or a falling edge (`polarity`=0) on `trig_in` while armed launches one sequence. `seq_start` is high after the third rising clock edge following the pin change.
- R5: With `trig_en`=1 and `level_mode`=1, the trigger is active while high (`polarity`=1) or while low (`polarity`=0). While armed, an active trigger launches a sequence with the same latency as R4. If the trigger is active in the cycle of `conv_done`, the next `seq_start` follows in the next cycle; otherwise the block returns to armed and `busy` drops.
- R6: With `trig_en`=1, `start_req` only arms the block: `busy` and `seq_start` are 0 in the next cycle and stay 0 until a qualifying trigger arrives. `scan_cont` has no effect.
- R7: In edge mode, a qualifying edge in any cycle where `busy` is high sets `ovr_flag` in the next cycle and launches no extra sequence.
- R8: In level mode, `ovr_flag` is never set, however the trigger toggles during a sequence.
- R9: `ovr_flag` stays set until `clr_ovr` or `start_req` is high, which clears it in the next cycle.
- R10: `start_req` while a sequence runs aborts that sequence and re-arms the block under the current mode bits. In software mode it starts a fresh sequence in the next cycle; with `trig_en`=1 it drops `busy` in the next cycle.
- R11: `conv_done` while `busy` is low is ignored: it starts nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| trig_in | input | 1 | Asynchronous external trigger pin |
| trig_en | input | 1 | 1: sequences are launched by the external trigger |
| level_mode | input | 1 | 1: level sensitive, 0: edge sensitive |
| polarity | input | 1 | 1: rising edge / high level, 0: falling edge / low level |
| scan_cont | input | 1 | Software mode: 1 repeats sequences back to back |
| start_req | input | 1 | One-cycle strobe when the conversion-control register is written |
| clr_ovr | input | 1 | One-cycle strobe that clears the overrun flag |
| conv_done | input | 1 | One-cycle pulse from the conversion engine at the end of a sequence |
| seq_start | output | 1 | One-cycle pulse that launches a conversion sequence |
| busy | output | 1 | High while a sequence is in progress |
| ovr_flag | output | 1 | Sticky edge-mode trigger overrun |

## Verification
The assertions check on every cycle that the start strobe launches or arms correctly, that `seq_start` never appears without `busy`, and that the overrun flag is sticky, clears on request and never rises in level mode. Only the bench scenarios can show the whole-sequence behaviour: the exact trigger-to-start latency through the synchronizer, the number of sequences launched per edge, back-to-back restarts while a level is held, and overruns raised by edges that arrive during a sequence. These are compared cycle by cycle against a reference model while the trigger pin and strobes are driven at random.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
// Synchronizes the trigger pin and derives the polarity-qualified level and edge.
module adc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic polarity,
  output logic lvl_act,
  output logic edge_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          s_prev;
  logic          s_cur;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= trig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign s_cur = chain[LAST];

  always_ff @(posedge clk) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_cur;
  end

  always_comb begin
    lvl_act  = polarity ? s_cur : ~s_cur;
    edge_hit = polarity ? (s_cur & ~s_prev) : (~s_cur & s_prev);
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
// Sequence state machine and overrun flag.
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_en,
  input  logic level_mode,
  input  logic scan_cont,
  input  logic start_req,
  input  logic clr_ovr,
  input  logic conv_done,
  input  logic lvl_act,
  input  logic edge_hit,
  output logic seq_start,
  output logic busy,
  output logic ovr_flag
);
  seq_state_e state_q, state_d;
  logic       launch;
  logic       ovr_d;
  logic       qualify;

  assign qualify = level_mode ? lvl_act : edge_hit;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    if (start_req) begin
      if (trig_en) begin
        state_d = ST_ARMED;
      end else begin
        state_d = ST_RUN;
        launch  = 1'b1;
      end
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (trig_en && qualify) begin
            state_d = ST_RUN;
            launch  = 1'b1;
          end
        end
        ST_RUN: begin
          if (conv_done) begin
            if (trig_en) begin
              if (level_mode && lvl_act) launch  = 1'b1;
              else                       state_d = ST_ARMED;
            end else if (scan_cont) begin
              launch = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    ovr_d = ovr_flag;
    if (start_req || clr_ovr)
      ovr_d = 1'b0;
    else if (state_q == ST_RUN && trig_en && !level_mode && edge_hit)
      ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      seq_start <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      state_q   <= state_d;
      seq_start <= launch;
      ovr_flag  <= ovr_d;
    end
  end

  assign busy = (state_q == ST_RUN);

  a_r2_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !trig_en) |=> (seq_start && busy));

  a_r6_arm_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && trig_en) |=> (!seq_start && !busy));

  a_r2_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req || clr_ovr) |=> !ovr_flag);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !start_req && !clr_ovr) |=> ovr_flag);

  a_r8_no_level_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_flag && trig_en && level_mode) |=> !ovr_flag);

  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_done && !start_req && !trig_en) |=> !busy);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic trig_en,
  input  logic level_mode,
  input  logic polarity,
  input  logic scan_cont,
  input  logic start_req,
  input  logic clr_ovr,
  input  logic conv_done,
  output logic seq_start,
  output logic busy,
  output logic ovr_flag
);
  logic lvl_act;
  logic edge_hit;

  adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .polarity (polarity),
    .lvl_act  (lvl_act),
    .edge_hit (edge_hit)
  );

  adc_trig_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_en    (trig_en),
    .level_mode (level_mode),
    .scan_cont  (scan_cont),
    .start_req  (start_req),
    .clr_ovr    (clr_ovr),
    .conv_done  (conv_done),
    .lvl_act    (lvl_act),
    .edge_hit   (edge_hit),
    .seq_start  (seq_start),
    .busy       (busy),
    .ovr_flag   (ovr_flag)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !seq_start && !ovr_flag));
endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0, trig_en = 1'b0, level_mode = 1'b0, polarity = 1'b0;
  logic scan_cont = 1'b0, start_req = 1'b0, clr_ovr = 1'b0;
  logic eng_done = 1'b0, inj_done = 1'b0;
  logic conv_done;
  logic seq_start, busy, ovr_flag;

  int n_chk = 0, n_fail = 0, pulses = 0, lat = 5, cnt = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  assign conv_done = eng_done | inj_done;

  always #2 clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(trig_en),
    .level_mode(level_mode), .polarity(polarity), .scan_cont(scan_cont),
    .start_req(start_req), .clr_ovr(clr_ovr), .conv_done(conv_done),
    .seq_start(seq_start), .busy(busy), .ovr_flag(ovr_flag)
  );

  // Reference model built from the requirements
  bit m_s1, m_s2, m_prev, m_seq, m_ovr;
  int m_st; // 0 idle, 1 armed, 2 run

  function automatic bit f_edge(bit pol, bit cur, bit prv);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  function automatic bit f_act(bit pol, bit cur);
    return pol ? cur : ~cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_seq = 0; m_ovr = 0; m_st = 0;
    end else begin
      bit hit, act, launch, novr;
      int ns;
      hit = f_edge(polarity, m_s2, m_prev);
      act = f_act(polarity, m_s2);
      launch = 0; ns = m_st; novr = m_ovr;
      if (start_req) begin
        if (trig_en) ns = 1; else begin ns = 2; launch = 1; end
      end else if (m_st == 1) begin
        if (trig_en && (level_mode ? act : hit)) begin ns = 2; launch = 1; end
      end else if (m_st == 2 && conv_done) begin
        if (trig_en) begin
          if (level_mode && act) launch = 1; else ns = 1;
        end else if (scan_cont) launch = 1;
        else ns = 0;
      end
      if (start_req || clr_ovr) novr = 0;
      else if (m_st == 2 && trig_en && !level_mode && hit) novr = 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = trig_in;
      m_st = ns; m_seq = launch; m_ovr = novr;
    end
  end

  // Conversion engine model: done pulse lat cycles after each start
  always @(negedge clk) begin
    if (seq_start) cnt = lat;
    else if (cnt != 0) cnt = cnt - 1;
    eng_done = (cnt == 1);
    if (seq_start) pulses++;
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (seq_start !== m_seq || busy !== (m_st == 2) || ovr_flag !== m_ovr) begin
        n_fail++;
        $display("FAIL %s model: got seq=%0b busy=%0b ovr=%0b exp seq=%0b busy=%0b ovr=%0b",
                 cur_req, seq_start, busy, ovr_flag, m_seq, (m_st == 2), m_ovr);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit en, bit lvl, bit pol, bit scan);
    trig_en = en; level_mode = lvl; polarity = pol; scan_cont = scan;
  endtask

  task automatic strobe_start();
    @(negedge clk); start_req = 1; @(negedge clk); start_req = 0;
  endtask

  task automatic strobe_clr();
    @(negedge clk); clr_ovr = 1; @(negedge clk); clr_ovr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b2c));
    cyc(4);
    rst_n = 1;
    cyc(2);
    cur_req = "R1";
    chk(!busy && !seq_start && !ovr_flag, "R1", {busy, seq_start, ovr_flag}, 0);
    pulses = 0; cyc(10);
    chk(pulses == 0, "R1", pulses, 0);

    // R11: stray done while idle
    cur_req = "R11";
    @(negedge clk); inj_done = 1; @(negedge clk); inj_done = 0;
    cyc(3);
    chk(!busy && pulses == 0, "R11", pulses + busy, 0);

    // R2: software single sequence
    cur_req = "R2"; lat = 5; cfg(0, 0, 0, 0);
    pulses = 0; strobe_start();
    chk(seq_start && busy, "R2", {seq_start, busy}, 3);
    cyc(20);
    chk(pulses == 1 && !busy, "R2", pulses, 1);

    // R3: software continuous, trigger ignored
    cur_req = "R3"; cfg(0, 0, 1, 1);
    pulses = 0; strobe_start();
    for (int k = 0; k < 6; k++) begin trig_in = ~trig_in; cyc(4); end
    cyc(10);
    chk(pulses >= 5 && busy, "R3", pulses, 5);

    // R10 + R6: abort into armed edge mode, no trigger, scan ignored
    cur_req = "R10"; cfg(1, 0, 1, 1); trig_in = 0;
    strobe_start();
    chk(!busy && !seq_start, "R10", busy, 0);
    cur_req = "R6"; pulses = 0; cyc(25);
    chk(pulses == 0 && !busy, "R6", pulses, 0);

    // R4: rising edges, latency and one sequence per edge
    cur_req = "R4";
    @(negedge clk); trig_in = 1;
    cyc(2); chk(!seq_start, "R4", seq_start, 0);
    cyc(1); chk(seq_start == 1, "R4", seq_start, 1);
    cyc(15); trig_in = 0; cyc(15); trig_in = 1; cyc(15); trig_in = 0; cyc(15); trig_in = 1; cyc(20);
    chk(pulses == 3 && !ovr_flag, "R4", pulses, 3);

    // R4: falling edges
    cfg(1, 0, 0, 0); trig_in = 1; cyc(5); strobe_start(); pulses = 0;
    for (int k = 0; k < 2; k++) begin trig_in = 0; cyc(15); trig_in = 1; cyc(15); end
    chk(pulses == 2, "R4", pulses, 2);

    // R7 + R9: overrun in edge mode
    cur_req = "R7"; cfg(1, 0, 1, 0); trig_in = 0; lat = 20;
    strobe_start(); pulses = 0; cyc(3);
    trig_in = 1; cyc(5); trig_in = 0; cyc(4); trig_in = 1; cyc(30);
    chk(ovr_flag == 1, "R7", ovr_flag, 1);
    chk(pulses == 1, "R7", pulses, 1);
    cur_req = "R9"; cyc(20);
    chk(ovr_flag == 1, "R9", ovr_flag, 1);
    strobe_clr();
    chk(ovr_flag == 0, "R9", ovr_flag, 0);

    // R5 + R8: active-high level mode with glitches during a sequence
    cur_req = "R5"; cfg(1, 1, 1, 0); trig_in = 0; lat = 10;
    strobe_start(); pulses = 0;
    trig_in = 1; cyc(8); trig_in = 0; cyc(2); trig_in = 1; cyc(50);
    chk(pulses >= 5 && busy, "R5", pulses, 5);
    chk(ovr_flag == 0, "R8", ovr_flag, 0);
    trig_in = 0; cyc(20);
    chk(!busy, "R5", busy, 0);

    // R5: active-low level
    cfg(1, 1, 0, 0); strobe_start(); pulses = 0; cyc(40);
    chk(pulses >= 3 && !ovr_flag, "R5", pulses, 3);
    trig_in = 1; cyc(20);
    chk(!busy, "R5", busy, 0);

    // Random phase against the model
    cur_req = "R3/R4/R5/R7/R8/R9/R10";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      start_req = 0; clr_ovr = 0;
      if ($urandom_range(99) < 15) trig_in = ~trig_in;
      if ($urandom_range(199) < 3) begin
        cfg($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
        lat = 2 + $urandom_range(9);
        start_req = 1;
      end else if ($urandom_range(99) < 2) clr_ovr = 1;
    end
    @(negedge clk); start_req = 0; clr_ovr = 0;
    cyc(5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule